// File: doc/BRIEF.md
# PC Card Byte-Lane Access Decoder

This block sits behind the host pins of a 16-bit PC Card slave. It sorts every host cycle into one of four kinds: attribute space, memory-mapped task file, I/O-mapped task file, or a drive cycle in the IDE personality. It then routes bytes between the 16-bit host data bus and a set of byte-wide internal registers.

The chip-enable pair and address bit 0 pick byte, word or odd-byte transfers. The block drives one output enable per host byte lane, so the pad ring knows which half of the data bus to drive. For each lane it also issues a register select and a read level and a single-cycle write pulse. It generates the 16-bit I/O indication and the input-acknowledge signal. The level of the output-enable pin sampled while reset is held selects the IDE personality.

The registers behind the task file and the attribute space are modelled by a small byte store inside the block, so that routed data can be observed.

Top module: `pccard_lane_decoder`

## Requirements
- R1: While `ce1_n` and `ce2_n` are both high, `lane_oe` is 00, `host_rdata` is 0 and no `int_wr` pulse is produced, whatever the strobes do.
- R2: Byte mode (`ce1_n`=0, `ce2_n`=1) addresses the byte at `addr` with bit 0 honoured. The data is carried on `host_rdata[7:0]`/`host_wdata[7:0]` with `lane_oe`=01.
- R3: Word mode (both enables low) ignores `addr[0]`. The even byte (`addr[0]` forced 0) uses bits 7:0, the odd byte (`addr[0]` forced 1) uses bits 15:8, and `lane_oe`=11.
- R4: Odd-byte mode (`ce1_n`=1, `ce2_n`=0) addresses the odd byte (`addr[0]` forced 1) on bits 15:8 with `lane_oe`=10.
- R5: With `reg_n`=0 and `oe_n`/`we_n`, attribute space is used, and it holds only even byte addresses. Reads of an odd address return 8'hFF on the lane that carries it. Writes to an odd address are dropped. Attribute space is separate from the task file.
- R6: Task file cycles hit only when `addr` < 16. With `cfg_io_en`=0 they use `reg_n`=1 with `oe_n`/`we_n`, and `iord_n`/`iowr_n` have no effect. With `cfg_io_en`=1 they use `reg_n`=0 with `iord_n`/`iowr_n`, and memory-mapped task file cycles are not answered.
- R7: `ide_mode` takes the inverse of `oe_n` at each clock edge while `rst_n` is low, and holds afterwards. In that mode only `iord_n`/`iowr_n` act. `ce1_n`=0, `ce2_n`=1 selects register `addr[2:0]`. Offset 0 is a 16-bit data register whose high byte is stored at task index 8.
- R8: In IDE mode, `ce1_n`=1, `ce2_n`=0 at offset 6 reads task index 7 (alternate status) and writes task index 14 (device control). Other offsets and both enables low produce no lane activity.
- R9: `iois16_n` is low when all of the following hold: `cfg_io_en`=1, `reg_n`=0, both enables low and a task file address, outside IDE mode. In IDE mode it is low when `ce1_n`=0, `ce2_n`=1 and `addr[2:0]`=0. It depends on no strobe.
- R10: `inpack_n` is low only during an answered I/O-mapped task file read. It stays high for attribute, memory-mapped and IDE cycles.
- R11: A lane output enable is active only while a read strobe is asserted. It drops in the same cycle the strobe rises.
- R12: Each write strobe produces exactly one single-cycle `int_wr` pulse per lane that receives data, however long the strobe is held.
- R13: Reset clears every task file and attribute byte to 0 and leaves `lane_oe`=00, `inpack_n`=1 and `iois16_n`=1 on idle pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; host pins are assumed already synchronised |
| rst_n | input | 1 | Synchronous active-low reset; also the personality sampling window |
| cfg_io_en | input | 1 | Card configured for the I/O interface |
| reg_n | input | 1 | Attribute / I/O space select, active low |
| ce1_n | input | 1 | Even-lane card enable, active low |
| ce2_n | input | 1 | Odd-lane card enable, active low |
| addr | input | ADDR_W | Host byte address |
| oe_n | input | 1 | Memory read strobe; sampled in reset as personality strap |
| we_n | input | 1 | Memory write strobe |
| iord_n | input | 1 | I/O read strobe |
| iowr_n | input | 1 | I/O write strobe |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data toward the pads |
| lane_oe | output | 2 | Pad output enable per byte lane (bit 0 low lane) |
| int_sel_attr | output | 1 | Current cycle targets attribute space |
| int_idx_lo | output | ADDR_W | Internal byte index carried on the low lane |
| int_idx_hi | output | ADDR_W | Internal byte index carried on the high lane |
| int_rd | output | 2 | Per-lane internal read select |
| int_wr | output | 2 | Per-lane single-cycle write pulse |
| iois16_n | output | 1 | 16-bit I/O indication, active low |
| inpack_n | output | 1 | Input acknowledge, active low |
| ide_mode | output | 1 | Latched IDE personality |

## Verification
On every clock, the assertions check that lanes stay quiet in standby and with both IDE enables low. They also check that an output enable always has a live read strobe behind it, that input acknowledge appears only with an I/O read in the PC Card personality, that a write pulse is never followed by another in the next cycle, and that attribute space never takes a high-lane write. The lane routing itself can only be shown by the bench scenarios. These cover which byte lands at which index, A0 being ignored in word mode, 8'hFF on odd attribute bytes, the split between memory and I/O maps, the alternate status and device control aliases, and the personality strap taken at reset. The scenarios write bytes and read them back through other access widths.

// File: rtl/pcc_pkg.sv
// Shared types for the PC Card byte-lane decoder.
// Assumes: one clock domain; host pins are synchronised before this block.
package pcc_pkg;

    // Kind of host cycle currently on the pins.
    typedef enum logic [2:0] {
        CYC_NONE  = 3'd0,
        CYC_ATTR  = 3'd1,
        CYC_MEMTF = 3'd2,
        CYC_IOTF  = 3'd3,
        CYC_IDE   = 3'd4
    } cyc_e;

    // Per-lane routing flags (the index travels on its own wire).
    typedef struct packed {
        logic act;   // lane carries this cycle
        logic ok;    // lane holds a real byte (else filler / dropped)
        logic attr;  // lane targets attribute space
    } lane_t;

    // Task file indices used by the IDE personality.
    localparam int IDE_DATA_HI_IDX = 8;
    localparam int IDE_ALT_IDX     = 7;
    localparam int IDE_CTL_IDX     = 14;
    localparam int IDE_ALT_OFS     = 6;

endpackage

// File: rtl/pcc_cycle_decode.sv
// Classifies the host pins into one cycle kind with a read or write level.
// Assumes: conflicting strobe combinations are rejected, never prioritised.
module pcc_cycle_decode
    import pcc_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int TF_ADDR_W = 4
) (
    input  logic              ide_mode,
    input  logic              cfg_io_en,
    input  logic              reg_n,
    input  logic              ce1_n,
    input  logic              ce2_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              iord_n,
    input  logic              iowr_n,
    output cyc_e              cyc,
    output logic              rd_act,
    output logic              wr_act
);

    logic any_ce, tf_hit;
    logic mem_rd, mem_wr, io_rd, io_wr, mem_any, io_any;

    // Strobe qualification: exactly one direction per space.
    always_comb begin
        any_ce  = !ce1_n || !ce2_n;
        tf_hit  = (addr >> TF_ADDR_W) == '0;
        mem_rd  = !oe_n && we_n;
        mem_wr  = !we_n && oe_n;
        io_rd   = !iord_n && iowr_n;
        io_wr   = !iowr_n && iord_n;
        mem_any = mem_rd || mem_wr;
        io_any  = io_rd || io_wr;
    end

    // Cycle classification for the active personality.
    always_comb begin
        cyc    = CYC_NONE;
        rd_act = 1'b0;
        wr_act = 1'b0;
        if (ide_mode) begin
            if (any_ce && io_any) begin
                cyc    = CYC_IDE;
                rd_act = io_rd;
                wr_act = io_wr;
            end
        end else if (any_ce) begin
            if (!reg_n && mem_any && !io_any) begin
                cyc    = CYC_ATTR;
                rd_act = mem_rd;
                wr_act = mem_wr;
            end else if (!reg_n && cfg_io_en && io_any && !mem_any && tf_hit) begin
                cyc    = CYC_IOTF;
                rd_act = io_rd;
                wr_act = io_wr;
            end else if (reg_n && !cfg_io_en && mem_any && !io_any && tf_hit) begin
                cyc    = CYC_MEMTF;
                rd_act = mem_rd;
                wr_act = mem_wr;
            end
        end
    end

endmodule

// File: rtl/pcc_lane_steer.sv
// Maps a classified cycle to per-lane byte indices and validity.
// Assumes: ADDR_W > TF_ADDR_W and the task file holds at least 16 bytes.
module pcc_lane_steer
    import pcc_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  cyc_e              cyc,
    input  logic              ce1_n,
    input  logic              ce2_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_act,
    output lane_t             lo,
    output lane_t             hi,
    output logic [ADDR_W-1:0] lo_idx,
    output logic [ADDR_W-1:0] hi_idx
);

    localparam logic [ADDR_W-1:0] DATA_HI = ADDR_W'(IDE_DATA_HI_IDX);
    localparam logic [ADDR_W-1:0] ALT_IDX = ADDR_W'(IDE_ALT_IDX);
    localparam logic [ADDR_W-1:0] CTL_IDX = ADDR_W'(IDE_CTL_IDX);

    logic [2:0]        ofs;
    logic [ADDR_W-1:0] even_a, odd_a;

    // Address forms shared by all personalities.
    always_comb begin
        ofs    = addr[2:0];
        even_a = {addr[ADDR_W-1:1], 1'b0};
        odd_a  = {addr[ADDR_W-1:1], 1'b1};
    end

    // Lane routing per cycle kind.
    always_comb begin
        lo     = '0;
        hi     = '0;
        lo_idx = '0;
        hi_idx = '0;
        case (cyc)
            CYC_IDE: begin
                if (!ce1_n && ce2_n) begin
                    lo.act = 1'b1;
                    lo.ok  = 1'b1;
                    lo_idx = ADDR_W'(ofs);
                    if (ofs == 3'd0) begin
                        hi.act = 1'b1;
                        hi.ok  = 1'b1;
                        hi_idx = DATA_HI;
                    end
                end else if (ce1_n && !ce2_n && ofs == 3'(IDE_ALT_OFS)) begin
                    lo.act = 1'b1;
                    lo.ok  = 1'b1;
                    lo_idx = rd_act ? ALT_IDX : CTL_IDX;
                end
            end
            CYC_ATTR, CYC_MEMTF, CYC_IOTF: begin
                if (!ce1_n) begin
                    lo.act = 1'b1;
                    lo_idx = ce2_n ? addr : even_a;
                end
                if (!ce2_n) begin
                    hi.act = 1'b1;
                    hi_idx = odd_a;
                end
                if (cyc == CYC_ATTR) begin
                    lo.attr = 1'b1;
                    hi.attr = 1'b1;
                    lo.ok   = lo.act && !lo_idx[0];
                    hi.ok   = 1'b0;
                end else begin
                    lo.ok = lo.act;
                    hi.ok = hi.act;
                end
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/pcc_byte_store.sv
// Byte-wide stand-in for the task file and attribute registers.
// Assumes: attribute space keeps only even bytes, so it is half the address span.
module pcc_byte_store
    import pcc_pkg::*;
#(
    parameter int          ADDR_W       = 6,
    parameter int          TF_ADDR_W    = 4,
    parameter logic [7:0]  INVALID_BYTE = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  lane_t             lo,
    input  lane_t             hi,
    input  logic [ADDR_W-1:0] lo_idx,
    input  logic [ADDR_W-1:0] hi_idx,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [7:0]        wdata_lo,
    input  logic [7:0]        wdata_hi,
    output logic [7:0]        rbyte_lo,
    output logic [7:0]        rbyte_hi
);

    localparam int TF_BYTES   = 1 << TF_ADDR_W;
    localparam int ATTR_BYTES = 1 << (ADDR_W - 1);

    logic [7:0] tf_q   [TF_BYTES];
    logic [7:0] attr_q [ATTR_BYTES];

    // Storage update: one write per lane per pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TF_BYTES; i++)   tf_q[i]   <= '0;
            for (int j = 0; j < ATTR_BYTES; j++) attr_q[j] <= '0;
        end else begin
            if (wr_lo && lo.ok) begin
                if (lo.attr) attr_q[lo_idx[ADDR_W-1:1]] <= wdata_lo;
                else         tf_q[lo_idx[TF_ADDR_W-1:0]] <= wdata_lo;
            end
            if (wr_hi && hi.ok) begin
                if (hi.attr) attr_q[hi_idx[ADDR_W-1:1]] <= wdata_hi;
                else         tf_q[hi_idx[TF_ADDR_W-1:0]] <= wdata_hi;
            end
        end
    end

    // Read byte for one lane, filler when the lane holds no real byte.
    function automatic logic [7:0] pick(input lane_t l, input logic [ADDR_W-1:0] ix);
        if (!l.ok)       return INVALID_BYTE;
        else if (l.attr) return attr_q[ix[ADDR_W-1:1]];
        else             return tf_q[ix[TF_ADDR_W-1:0]];
    endfunction

    // Read ports for both lanes.
    always_comb begin
        rbyte_lo = pick(lo, lo_idx);
        rbyte_hi = pick(hi, hi_idx);
    end

endmodule

// File: rtl/pccard_lane_decoder.sv
// Top of the PC Card byte-lane decoder: personality latch, cycle decode,
// lane steering, write pulse generation and host-side status pins.
// Assumes: pins synchronised to clk; pad ring gates drivers with lane_oe.
module pccard_lane_decoder
    import pcc_pkg::*;
#(
    parameter int         ADDR_W       = 6,
    parameter int         TF_ADDR_W    = 4,
    parameter logic [7:0] INVALID_BYTE = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_io_en,
    input  logic              reg_n,
    input  logic              ce1_n,
    input  logic              ce2_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              iord_n,
    input  logic              iowr_n,
    input  logic [15:0]       host_wdata,
    output logic [15:0]       host_rdata,
    output logic [1:0]        lane_oe,
    output logic              int_sel_attr,
    output logic [ADDR_W-1:0] int_idx_lo,
    output logic [ADDR_W-1:0] int_idx_hi,
    output logic [1:0]        int_rd,
    output logic [1:0]        int_wr,
    output logic              iois16_n,
    output logic              inpack_n,
    output logic              ide_mode
);

    logic              ide_q, wr_q, wr_first;
    cyc_e              cyc;
    logic              rd_act, wr_act, tf_hit;
    lane_t             lo, hi;
    logic [ADDR_W-1:0] lo_idx, hi_idx;
    logic [7:0]        rbyte_lo, rbyte_hi;

    // Personality strap: follow the inverted read strobe while in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ide_q <= !oe_n;
    end

    // Previous write level, for one pulse per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_q <= 1'b0;
        else        wr_q <= wr_act;
    end

    pcc_cycle_decode #(.ADDR_W(ADDR_W), .TF_ADDR_W(TF_ADDR_W)) u_dec (
        .ide_mode (ide_q),
        .cfg_io_en(cfg_io_en),
        .reg_n    (reg_n),
        .ce1_n    (ce1_n),
        .ce2_n    (ce2_n),
        .addr     (addr),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .iord_n   (iord_n),
        .iowr_n   (iowr_n),
        .cyc      (cyc),
        .rd_act   (rd_act),
        .wr_act   (wr_act)
    );

    pcc_lane_steer #(.ADDR_W(ADDR_W)) u_steer (
        .cyc   (cyc),
        .ce1_n (ce1_n),
        .ce2_n (ce2_n),
        .addr  (addr),
        .rd_act(rd_act),
        .lo    (lo),
        .hi    (hi),
        .lo_idx(lo_idx),
        .hi_idx(hi_idx)
    );

    pcc_byte_store #(.ADDR_W(ADDR_W), .TF_ADDR_W(TF_ADDR_W),
                     .INVALID_BYTE(INVALID_BYTE)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .lo      (lo),
        .hi      (hi),
        .lo_idx  (lo_idx),
        .hi_idx  (hi_idx),
        .wr_lo   (int_wr[0]),
        .wr_hi   (int_wr[1]),
        .wdata_lo(host_wdata[7:0]),
        .wdata_hi(host_wdata[15:8]),
        .rbyte_lo(rbyte_lo),
        .rbyte_hi(rbyte_hi)
    );

    // Lane enables, internal selects and write pulses.
    always_comb begin
        wr_first     = wr_act && !wr_q;
        lane_oe[0]   = rd_act && lo.act;
        lane_oe[1]   = rd_act && hi.act;
        int_rd[0]    = lane_oe[0] && lo.ok;
        int_rd[1]    = lane_oe[1] && hi.ok;
        int_wr[0]    = wr_first && lo.act && lo.ok;
        int_wr[1]    = wr_first && hi.act && hi.ok;
        int_sel_attr = (cyc == CYC_ATTR);
        int_idx_lo   = lo_idx;
        int_idx_hi   = hi_idx;
        host_rdata   = {lane_oe[1] ? rbyte_hi : 8'h00, lane_oe[0] ? rbyte_lo : 8'h00};
    end

    // Host status pins: 16-bit indication and input acknowledge.
    always_comb begin
        ide_mode = ide_q;
        tf_hit   = (addr >> TF_ADDR_W) == '0;
        if (ide_q) iois16_n = !(!ce1_n && ce2_n && addr[2:0] == 3'd0);
        else       iois16_n = !(cfg_io_en && !reg_n && !ce1_n && !ce2_n && tf_hit);
        inpack_n = !(cyc == CYC_IOTF && rd_act);
    end

    // R1: standby keeps both lanes quiet.
    assert_standby_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ce1_n && ce2_n) |-> (lane_oe == 2'b00 && int_wr == 2'b00));

    // R5: attribute space never takes a high-lane write.
    assert_attr_no_odd_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (int_wr[1] && !ide_mode) |-> reg_n || cfg_io_en);

    // R8: both enables low in IDE mode is an invalid cycle.
    assert_ide_both_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ide_mode && !ce1_n && !ce2_n) |-> (lane_oe == 2'b00 && int_wr == 2'b00));

    // R10: acknowledge only for an I/O read in the PC Card personality.
    assert_inpack_io_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !inpack_n |-> (!iord_n && !reg_n && cfg_io_en && !ide_mode));

    // R11: an output enable needs a live read strobe.
    assert_oe_needs_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_oe != 2'b00) |-> (ide_mode ? !iord_n : (!oe_n || !iord_n)));

    // R12: a write pulse lasts one cycle.
    assert_wr_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (int_wr != 2'b00) |=> (int_wr == 2'b00));

endmodule

// File: tb/pccard_lane_decoder_test.sv
// Scoreboard bench: driver tasks queue expected pin states, a monitor compares.
module pccard_lane_decoder_test;
    localparam int ADDR_W = 6;

    logic clk = 1'b0;
    logic rst_n, cfg_io_en, reg_n, ce1_n, ce2_n, oe_n, we_n, iord_n, iowr_n;
    logic [ADDR_W-1:0] addr;
    logic [15:0] host_wdata, host_rdata;
    logic [1:0]  lane_oe, int_rd, int_wr;
    logic        int_sel_attr, iois16_n, inpack_n, ide_mode;
    logic [ADDR_W-1:0] int_idx_lo, int_idx_hi;

    int checks = 0, failures = 0;
    int cnt_lo = 0, cnt_hi = 0;
    int base_lo, base_hi;
    bit done = 0;
    logic idle_oe = 1'b1;

    typedef struct {
        string       tag;
        logic [15:0] rdata;
        logic [1:0]  oe;
        logic        iois;
        logic        inpack;
    } exp_t;
    exp_t exp_q[$];
    event sample_ev;

    always #5 clk = ~clk;

    pccard_lane_decoder #(.ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_io_en(cfg_io_en), .reg_n(reg_n),
        .ce1_n(ce1_n), .ce2_n(ce2_n), .addr(addr), .oe_n(oe_n), .we_n(we_n),
        .iord_n(iord_n), .iowr_n(iowr_n), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .lane_oe(lane_oe), .int_sel_attr(int_sel_attr),
        .int_idx_lo(int_idx_lo), .int_idx_hi(int_idx_hi), .int_rd(int_rd),
        .int_wr(int_wr), .iois16_n(iois16_n), .inpack_n(inpack_n), .ide_mode(ide_mode)
    );

    // Write pulse counters per lane.
    always @(posedge clk) begin
        if (rst_n === 1'b1) begin
            if (int_wr[0]) cnt_lo++;
            if (int_wr[1]) cnt_hi++;
        end
    end

    // Monitor: pop the expected state and compare it with the pins.
    always begin
        @(sample_ev);
        #1;
        begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (host_rdata !== e.rdata || lane_oe !== e.oe ||
                iois16_n !== e.iois || inpack_n !== e.inpack) begin
                failures++;
                $display("FAIL %s act rdata=%h oe=%b iois=%b inp=%b exp rdata=%h oe=%b iois=%b inp=%b",
                         e.tag, host_rdata, lane_oe, iois16_n, inpack_n,
                         e.rdata, e.oe, e.iois, e.inpack);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp_v);
        end
    endtask

    task automatic expect_pins(input string tag, input logic [15:0] rd,
                               input logic [1:0] oe, input logic io16, input logic inp);
        exp_t e;
        e.tag = tag; e.rdata = rd; e.oe = oe; e.iois = io16; e.inpack = inp;
        exp_q.push_back(e);
        -> sample_ev;
        #2;
    endtask

    task automatic idle_pins();
        reg_n = 1'b1; ce1_n = 1'b1; ce2_n = 1'b1; addr = '0;
        oe_n = idle_oe; we_n = 1'b1; iord_n = 1'b1; iowr_n = 1'b1; host_wdata = '0;
    endtask

    // One write cycle; io selects the I/O strobe, strobe held three clocks.
    task automatic wr_cycle(input logic r, input logic c1, input logic c2,
                            input logic [ADDR_W-1:0] a, input bit io, input logic [15:0] wd);
        @(negedge clk);
        reg_n = r; ce1_n = c1; ce2_n = c2; addr = a; host_wdata = wd;
        if (io) iowr_n = 1'b0; else we_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        idle_pins();
    endtask

    // One read cycle with the expected pin state.
    task automatic rd_cycle(input string tag, input logic r, input logic c1, input logic c2,
                            input logic [ADDR_W-1:0] a, input bit io,
                            input logic [15:0] rd, input logic [1:0] oe,
                            input logic io16, input logic inp);
        @(negedge clk);
        reg_n = r; ce1_n = c1; ce2_n = c2; addr = a;
        if (io) iord_n = 1'b0; else oe_n = 1'b0;
        expect_pins(tag, rd, oe, io16, inp);
        @(negedge clk);
        idle_pins();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_io_en = 1'b0; idle_pins();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R13 reset state, R7 personality from high strap
        expect_pins("R13 idle after reset", 16'h0000, 2'b00, 1'b1, 1'b1);
        chk("R7 ide_mode low strap", int'(ide_mode), 0);

        // Memory-mapped task file writes, several widths
        wr_cycle(1, 0, 1, 6'd2, 0, 16'h0011);
        wr_cycle(1, 0, 1, 6'd3, 0, 16'h0022);
        wr_cycle(1, 0, 0, 6'd4, 0, 16'h4433);
        wr_cycle(1, 1, 0, 6'd6, 0, 16'h5500);
        chk("R12 low lane pulses", cnt_lo, 3);
        chk("R12 high lane pulses", cnt_hi, 2);
        rd_cycle("R2 byte odd addr", 1, 0, 1, 6'd3, 0, 16'h0022, 2'b01, 1, 1);
        rd_cycle("R2 byte even addr", 1, 0, 1, 6'd2, 0, 16'h0011, 2'b01, 1, 1);
        rd_cycle("R3 word even", 1, 0, 0, 6'd2, 0, 16'h2211, 2'b11, 1, 1);
        rd_cycle("R3 word A0 ignored", 1, 0, 0, 6'd5, 0, 16'h4433, 2'b11, 1, 1);
        rd_cycle("R4 odd byte", 1, 1, 0, 6'd6, 0, 16'h5500, 2'b10, 1, 1);
        rd_cycle("R1 standby with OE", 1, 1, 1, 6'd2, 0, 16'h0000, 2'b00, 1, 1);
        rd_cycle("R6 IORD ignored memory", 0, 0, 0, 6'd4, 1, 16'h0000, 2'b00, 1, 1);

        // Attribute space
        wr_cycle(0, 0, 1, 6'h10, 0, 16'h00A5);
        wr_cycle(0, 0, 1, 6'h11, 0, 16'h005A);
        wr_cycle(0, 0, 0, 6'h12, 0, 16'h7766);
        wr_cycle(0, 0, 1, 6'h02, 0, 16'h0099);
        chk("R5 R12 low pulses after attr", cnt_lo, 6);
        chk("R5 odd attr no high pulse", cnt_hi, 2);
        rd_cycle("R5 attr even byte", 0, 0, 1, 6'h10, 0, 16'h00A5, 2'b01, 1, 1);
        rd_cycle("R5 attr odd byte filler", 0, 0, 1, 6'h11, 0, 16'h00FF, 2'b01, 1, 1);
        rd_cycle("R5 attr word", 0, 0, 0, 6'h12, 0, 16'hFF66, 2'b11, 1, 1);
        rd_cycle("R5 attr odd mode", 0, 1, 0, 6'h10, 0, 16'hFF00, 2'b10, 1, 1);
        rd_cycle("R5 attr addr2", 0, 0, 1, 6'h02, 0, 16'h0099, 2'b01, 1, 1);
        rd_cycle("R5 task file untouched", 1, 0, 1, 6'h02, 0, 16'h0011, 2'b01, 1, 1);

        // I/O interface
        cfg_io_en = 1'b1;
        rd_cycle("R9 R10 io word", 0, 0, 0, 6'd4, 1, 16'h4433, 2'b11, 0, 0);
        rd_cycle("R9 io byte not 16", 0, 0, 1, 6'd4, 1, 16'h0033, 2'b01, 1, 0);
        rd_cycle("R6 memory map off", 1, 0, 1, 6'd2, 0, 16'h0000, 2'b00, 1, 1);
        wr_cycle(0, 0, 1, 6'd8, 1, 16'h00C3);
        rd_cycle("R6 io write readback", 0, 0, 1, 6'd8, 1, 16'h00C3, 2'b01, 1, 0);
        rd_cycle("R6 io out of range", 0, 0, 0, 6'h20, 1, 16'h0000, 2'b00, 1, 1);
        rd_cycle("R10 attr read no ack", 0, 0, 1, 6'h10, 0, 16'h00A5, 2'b01, 1, 1);
        // R11: strobe release drops enables at once
        @(negedge clk);
        reg_n = 0; ce1_n = 0; ce2_n = 0; addr = 6'd4; iord_n = 0;
        expect_pins("R11 strobe held", 16'h4433, 2'b11, 0, 0);
        iord_n = 1;
        expect_pins("R11 strobe released", 16'h0000, 2'b00, 0, 1);
        @(negedge clk); idle_pins();

        // IDE personality: strap low through reset
        cfg_io_en = 1'b0; idle_oe = 1'b0; idle_pins();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        chk("R7 ide_mode latched", int'(ide_mode), 1);
        rd_cycle("R13 cleared by reset", 1, 0, 1, 6'd3, 1, 16'h0000, 2'b01, 1, 1);
        base_lo = cnt_lo; base_hi = cnt_hi;
        wr_cycle(1, 0, 1, 6'd3, 1, 16'h003C);
        wr_cycle(1, 0, 1, 6'd0, 1, 16'hBEEF);
        wr_cycle(1, 1, 0, 6'd6, 1, 16'h0002);
        wr_cycle(1, 0, 1, 6'd7, 1, 16'h0050);
        chk("R8 R12 ide low pulses", cnt_lo - base_lo, 4);
        chk("R7 ide high pulses", cnt_hi - base_hi, 1);
        rd_cycle("R7 ide reg 3", 1, 0, 1, 6'd3, 1, 16'h003C, 2'b01, 1, 1);
        rd_cycle("R7 R9 ide data word", 1, 0, 1, 6'd0, 1, 16'hBEEF, 2'b11, 0, 1);
        rd_cycle("R8 alt status", 1, 1, 0, 6'd6, 1, 16'h0050, 2'b01, 1, 1);
        rd_cycle("R8 both enables low", 1, 0, 0, 6'd0, 1, 16'h0000, 2'b00, 1, 1);
        rd_cycle("R8 ce2 other offset", 1, 1, 0, 6'd5, 1, 16'h0000, 2'b00, 1, 1);
        @(negedge clk);
        ce1_n = 0; ce2_n = 1; addr = 6'd0;
        expect_pins("R9 ide no strobe", 16'h0000, 2'b00, 0, 1);
        addr = 6'd3;
        expect_pins("R11 OE ignored in ide", 16'h0000, 2'b00, 1, 1);
        @(negedge clk); idle_pins();

        repeat (2) @(posedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule